// File: doc/BRIEF.md
# Register Rename Map with Move and Zero Elimination

This block turns a group of decoded operations into renamed operations in one step. It keeps a map from every architectural register to a physical register, plus a zero flag per architectural register. A register whose flag is set holds no physical register. Any reader of that register gets a zero indication instead of a tag, so zero data can be supplied at operand bypass. Physical registers come from a pool, and each one carries a reference count.

Each operation has a class: normal, move or zero idiom. A normal writer gets a fresh physical register. A move is finished inside the map: the destination takes over the source's tag, or the source's zero flag, and that tag's reference count goes up by one. A zero idiom sets the destination's zero flag and depends on nothing. Moves and zero idioms come out marked as eliminated, so they need no scheduler or execution slot.

Every writer also reports the mapping it replaced. The retire stage returns those replaced tags on the commit port. A physical register goes back to the pool only once its count falls to zero. A later operation in a group sees the mappings written by earlier operations in the same group. If the pool cannot supply a register for every normal writer in the group, the whole group stalls.

Top module: `rename_core`

## Requirements
- R1: After reset every architectural register is in the zero state, every physical register is free, `rn_valid` is all zero and `in_ready` is 1.
- R2: A normal operation with a destination receives a physical register that is free. Free registers are handed out in ascending index order, slot 0 of the group first.
- R3: For a normal operation, each enabled source whose register is mapped reports `rn_src_dep`=1 together with the mapped tag. Each enabled source whose register is in the zero state reports `rn_src_zero`=1, `rn_src_dep`=0 and tag 0.
- R4: A move (class 1, source taken from source slot 0) is marked eliminated. Its destination takes the source's tag, and no physical register is allocated for it.
- R5: A move whose source is in the zero state makes its destination zero (`rn_dst_zero`=1, tag 0) and takes no reference.
- R6: A zero idiom (class 2) is marked eliminated and makes its destination zero. It reports no source dependency and no source zero flag, even when its sources are enabled. It needs no free register.
- R7: Within one group, an operation reading a register written by an earlier slot sees that slot's new tag or zero state.
- R8: Every writer reports the replaced mapping: `rn_prev_valid`=1 with the old tag if the destination was mapped, or `rn_prev_valid`=0 if it was in the zero state.
- R9: A physical register returns to the pool only when commits have released every reference to it. A register shared through a move needs two commits.
- R10: `in_ready` is 0 when the normal writers in the group outnumber the free registers. A group that is not accepted renames nothing, and it changes neither the map nor the pool.
- R11: The results of an accepted group appear on the `rn_*` outputs one clock after acceptance. In any cycle after a cycle with no accepted group, `rn_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | GROUP | Slot holds an operation |
| op_cls | input | GROUP×2 | Class: 0 normal, 1 move, 2 zero idiom |
| op_dst_en | input | GROUP | Operation writes a destination |
| op_dst | input | GROUP×AW | Destination architectural register |
| op_src_en | input | GROUP×2 | Source enables, bit 0 is source slot 0 |
| op_src | input | GROUP×2×AW | Source architectural registers |
| in_ready | output | 1 | Group can be renamed this cycle |
| cm_valid | input | GROUP | Commit releases one reference |
| cm_tag | input | GROUP×PW | Physical register being released |
| rn_valid | output | GROUP | Renamed slot valid |
| rn_elim | output | GROUP | Slot was eliminated (move or zero idiom) |
| rn_dst_zero | output | GROUP | Destination is now zero |
| rn_dst_tag | output | GROUP×PW | Destination physical register |
| rn_prev_valid | output | GROUP | A replaced mapping exists |
| rn_prev_tag | output | GROUP×PW | Replaced physical register |
| rn_src_dep | output | GROUP×2 | Source must wait on its tag |
| rn_src_zero | output | GROUP×2 | Source reads as zero |
| rn_src_tag | output | GROUP×2×PW | Source physical register |

## Verification
Single-operation groups form a chain of normal writes, moves from mapped and from zero registers, and a zero idiom on a self-reading register. This chain tells tag copying apart from allocation, and it tells a zero source apart from a mapped one. A mixed group then chains a write, a move of that write, a reader of both, and a zeroing of the first destination. This shows forwarding within the group, and it shows that a later slot overrides an earlier one. The pool is drained down to its last registers, so the stall on too few free registers can be seen, along with the fact that eliminated operations still pass. Staged commits then show that a shared register comes back only after its second release.

// File: rtl/rat_pkg.sv
package rat_pkg;
    typedef enum logic [1:0] {
        CLS_NORMAL = 2'd0,
        CLS_MOVE   = 2'd1,
        CLS_ZERO   = 2'd2
    } op_class_e;
endpackage

// File: rtl/rat_free_pick.sv
// Selects the GROUP lowest-numbered free physical registers.
module rat_free_pick #(
    parameter int NPHYS = 180,
    parameter int GROUP = 6,
    parameter int PW    = $clog2(NPHYS),
    parameter int CNTG  = $clog2(GROUP + 1)
) (
    input  logic [NPHYS-1:0]          free_i,
    output logic [GROUP-1:0][PW-1:0]  pick_tag_o,
    output logic [GROUP-1:0]          pick_ok_o,
    output logic [CNTG-1:0]           avail_o
);
    logic [NPHYS-1:0] rem;
    int               cnt;

    always_comb begin
        rem = free_i;
        cnt = 0;
        for (int k = 0; k < GROUP; k++) begin
            pick_ok_o[k]  = 1'b0;
            pick_tag_o[k] = '0;
            for (int i = 0; i < NPHYS; i++) begin
                if (!pick_ok_o[k] && rem[i]) begin
                    pick_ok_o[k]  = 1'b1;
                    pick_tag_o[k] = PW'(i);
                end
            end
            if (pick_ok_o[k]) begin
                rem[pick_tag_o[k]] = 1'b0;
                cnt = cnt + 1;
            end
        end
        avail_o = CNTG'(cnt);
    end
endmodule

// File: rtl/rat_refcount.sv
// Per-physical-register reference counters; zero count means free.
module rat_refcount #(
    parameter int NPHYS = 180,
    parameter int GROUP = 6,
    parameter int CNTW  = 6,
    parameter int PW    = $clog2(NPHYS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [2*GROUP-1:0]          add_v_i,
    input  logic [2*GROUP-1:0][PW-1:0]  add_tag_i,
    input  logic [GROUP-1:0]            sub_v_i,
    input  logic [GROUP-1:0][PW-1:0]    sub_tag_i,
    output logic [NPHYS-1:0]            free_o
);
    localparam int CNT_MAX = (1 << CNTW) - 1;

    typedef struct packed {
        logic [NPHYS-1:0][CNTW-1:0] cnt;
    } state_t;

    state_t st_d, st_q;
    logic   underflow, overflow;
    int     n_add, n_sub;

    always_comb begin
        st_d      = st_q;
        underflow = 1'b0;
        overflow  = 1'b0;
        for (int p = 0; p < NPHYS; p++) begin
            n_add = 0;
            n_sub = 0;
            for (int j = 0; j < 2*GROUP; j++)
                if (add_v_i[j] && add_tag_i[j] == PW'(p)) n_add = n_add + 1;
            for (int j = 0; j < GROUP; j++)
                if (sub_v_i[j] && sub_tag_i[j] == PW'(p)) n_sub = n_sub + 1;
            if (int'(st_q.cnt[p]) + n_add < n_sub)             underflow = 1'b1;
            if (int'(st_q.cnt[p]) + n_add - n_sub > CNT_MAX)   overflow  = 1'b1;
            st_d.cnt[p] = st_q.cnt[p] + CNTW'(n_add) - CNTW'(n_sub);
            free_o[p]   = (st_q.cnt[p] == '0);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R9: a release never targets a register with no reference left
    p_no_underflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !underflow);
    // R9: sharing through moves never wraps a counter
    p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !overflow);
endmodule

// File: rtl/rat_group_rename.sv
// Combinational rename of one group against the current map.
module rat_group_rename import rat_pkg::*; #(
    parameter int GROUP = 6,
    parameter int NARCH = 16,
    parameter int NPHYS = 180,
    parameter int AW    = $clog2(NARCH),
    parameter int PW    = $clog2(NPHYS),
    parameter int CNTG  = $clog2(GROUP + 1)
) (
    input  logic [NARCH-1:0][PW-1:0]       map_tag_i,
    input  logic [NARCH-1:0]               map_zero_i,
    input  logic [GROUP-1:0][PW-1:0]       pick_tag_i,
    input  logic [GROUP-1:0]               op_valid_i,
    input  logic [GROUP-1:0][1:0]          op_cls_i,
    input  logic [GROUP-1:0]               op_dst_en_i,
    input  logic [GROUP-1:0][AW-1:0]       op_dst_i,
    input  logic [GROUP-1:0][1:0]          op_src_en_i,
    input  logic [GROUP-1:0][1:0][AW-1:0]  op_src_i,
    output logic [NARCH-1:0][PW-1:0]       map_tag_o,
    output logic [NARCH-1:0]               map_zero_o,
    output logic [CNTG-1:0]                need_o,
    output logic [GROUP-1:0]               alloc_v_o,
    output logic [GROUP-1:0][PW-1:0]       alloc_tag_o,
    output logic [GROUP-1:0]               inc_v_o,
    output logic [GROUP-1:0][PW-1:0]       inc_tag_o,
    output logic [GROUP-1:0]               elim_o,
    output logic [GROUP-1:0]               dst_zero_o,
    output logic [GROUP-1:0][PW-1:0]       dst_tag_o,
    output logic [GROUP-1:0]               prev_v_o,
    output logic [GROUP-1:0][PW-1:0]       prev_tag_o,
    output logic [GROUP-1:0][1:0]          src_dep_o,
    output logic [GROUP-1:0][1:0]          src_zero_o,
    output logic [GROUP-1:0][1:0][PW-1:0]  src_tag_o
);
    int            k;
    logic          is_mv, is_zi, new_zero;
    logic [PW-1:0] new_tag;
    logic [AW-1:0] sa, da;

    always_comb begin
        map_tag_o  = map_tag_i;
        map_zero_o = map_zero_i;
        k          = 0;
        alloc_v_o  = '0;  alloc_tag_o = '0;
        inc_v_o    = '0;  inc_tag_o   = '0;
        elim_o     = '0;  dst_zero_o  = '0;  dst_tag_o  = '0;
        prev_v_o   = '0;  prev_tag_o  = '0;
        src_dep_o  = '0;  src_zero_o  = '0;  src_tag_o  = '0;
        is_mv = 1'b0; is_zi = 1'b0; new_zero = 1'b0; new_tag = '0;
        sa = '0; da = '0;
        for (int i = 0; i < GROUP; i++) begin
            if (op_valid_i[i]) begin
                is_mv     = (op_cls_i[i] == CLS_MOVE);
                is_zi     = (op_cls_i[i] == CLS_ZERO);
                elim_o[i] = is_mv || is_zi;
                // sources see all earlier slots of the group
                for (int s = 0; s < 2; s++) begin
                    sa = op_src_i[i][s];
                    if (!is_zi && op_src_en_i[i][s]) begin
                        src_zero_o[i][s] = map_zero_o[sa];
                        src_tag_o[i][s]  = map_zero_o[sa] ? '0 : map_tag_o[sa];
                        src_dep_o[i][s]  = !is_mv && !map_zero_o[sa];
                    end
                end
                if (op_dst_en_i[i]) begin
                    da            = op_dst_i[i];
                    prev_v_o[i]   = !map_zero_o[da];
                    prev_tag_o[i] = map_zero_o[da] ? '0 : map_tag_o[da];
                    if (is_zi) begin
                        new_zero = 1'b1;
                        new_tag  = '0;
                    end else if (is_mv) begin
                        sa       = op_src_i[i][0];
                        new_zero = map_zero_o[sa];
                        new_tag  = map_zero_o[sa] ? '0 : map_tag_o[sa];
                        inc_v_o[i]   = !new_zero;
                        inc_tag_o[i] = new_tag;
                    end else begin
                        new_zero = 1'b0;
                        new_tag  = (k < GROUP) ? pick_tag_i[k] : '0;
                        alloc_v_o[i]   = 1'b1;
                        alloc_tag_o[i] = new_tag;
                        k = k + 1;
                    end
                    dst_zero_o[i]  = new_zero;
                    dst_tag_o[i]   = new_tag;
                    map_zero_o[da] = new_zero;
                    map_tag_o[da]  = new_tag;
                end
            end
        end
        need_o = CNTG'(k);
    end
endmodule

// File: rtl/rename_core.sv
module rename_core import rat_pkg::*; #(
    parameter int GROUP = 6,
    parameter int NARCH = 16,
    parameter int NPHYS = 180,
    parameter int CNTW  = 6,
    localparam int AW   = $clog2(NARCH),
    localparam int PW   = $clog2(NPHYS),
    localparam int CNTG = $clog2(GROUP + 1)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [GROUP-1:0]               op_valid,
    input  logic [GROUP-1:0][1:0]          op_cls,
    input  logic [GROUP-1:0]               op_dst_en,
    input  logic [GROUP-1:0][AW-1:0]       op_dst,
    input  logic [GROUP-1:0][1:0]          op_src_en,
    input  logic [GROUP-1:0][1:0][AW-1:0]  op_src,
    output logic                           in_ready,
    input  logic [GROUP-1:0]               cm_valid,
    input  logic [GROUP-1:0][PW-1:0]       cm_tag,
    output logic [GROUP-1:0]               rn_valid,
    output logic [GROUP-1:0]               rn_elim,
    output logic [GROUP-1:0]               rn_dst_zero,
    output logic [GROUP-1:0][PW-1:0]       rn_dst_tag,
    output logic [GROUP-1:0]               rn_prev_valid,
    output logic [GROUP-1:0][PW-1:0]       rn_prev_tag,
    output logic [GROUP-1:0][1:0]          rn_src_dep,
    output logic [GROUP-1:0][1:0]          rn_src_zero,
    output logic [GROUP-1:0][1:0][PW-1:0]  rn_src_tag
);
    typedef struct packed {
        logic [NARCH-1:0][PW-1:0]       map_tag;
        logic [NARCH-1:0]               map_zero;
        logic [GROUP-1:0]               valid;
        logic [GROUP-1:0]               elim;
        logic [GROUP-1:0]               dst_zero;
        logic [GROUP-1:0][PW-1:0]       dst_tag;
        logic [GROUP-1:0]               prev_v;
        logic [GROUP-1:0][PW-1:0]       prev_tag;
        logic [GROUP-1:0][1:0]          src_dep;
        logic [GROUP-1:0][1:0]          src_zero;
        logic [GROUP-1:0][1:0][PW-1:0]  src_tag;
    } state_t;

    state_t st_d, st_q;

    logic [NPHYS-1:0]              free_vec;
    logic [GROUP-1:0][PW-1:0]      pick_tag;
    logic [GROUP-1:0]              pick_ok;
    logic [CNTG-1:0]               avail, need;
    logic [NARCH-1:0][PW-1:0]      nxt_tag;
    logic [NARCH-1:0]              nxt_zero;
    logic [GROUP-1:0]              alloc_v, inc_v;
    logic [GROUP-1:0][PW-1:0]      alloc_tag, inc_tag;
    logic [GROUP-1:0]              g_elim, g_dzero, g_pv;
    logic [GROUP-1:0][PW-1:0]      g_dtag, g_ptag;
    logic [GROUP-1:0][1:0]         g_sdep, g_szero;
    logic [GROUP-1:0][1:0][PW-1:0] g_stag;
    logic                          fire;
    logic [2*GROUP-1:0]            add_v;
    logic [2*GROUP-1:0][PW-1:0]    add_tag;

    rat_free_pick #(.NPHYS(NPHYS), .GROUP(GROUP), .PW(PW), .CNTG(CNTG)) u_pick (
        .free_i(free_vec), .pick_tag_o(pick_tag), .pick_ok_o(pick_ok), .avail_o(avail)
    );

    rat_group_rename #(.GROUP(GROUP), .NARCH(NARCH), .NPHYS(NPHYS),
                       .AW(AW), .PW(PW), .CNTG(CNTG)) u_grp (
        .map_tag_i(st_q.map_tag), .map_zero_i(st_q.map_zero), .pick_tag_i(pick_tag),
        .op_valid_i(op_valid), .op_cls_i(op_cls), .op_dst_en_i(op_dst_en),
        .op_dst_i(op_dst), .op_src_en_i(op_src_en), .op_src_i(op_src),
        .map_tag_o(nxt_tag), .map_zero_o(nxt_zero), .need_o(need),
        .alloc_v_o(alloc_v), .alloc_tag_o(alloc_tag),
        .inc_v_o(inc_v), .inc_tag_o(inc_tag),
        .elim_o(g_elim), .dst_zero_o(g_dzero), .dst_tag_o(g_dtag),
        .prev_v_o(g_pv), .prev_tag_o(g_ptag),
        .src_dep_o(g_sdep), .src_zero_o(g_szero), .src_tag_o(g_stag)
    );

    assign in_ready = (need <= avail);
    assign fire     = in_ready && (|op_valid);
    assign add_v    = {inc_v & {GROUP{fire}}, alloc_v & {GROUP{fire}}};
    assign add_tag  = {inc_tag, alloc_tag};

    rat_refcount #(.NPHYS(NPHYS), .GROUP(GROUP), .CNTW(CNTW), .PW(PW)) u_ref (
        .clk(clk), .rst_n(rst_n),
        .add_v_i(add_v), .add_tag_i(add_tag),
        .sub_v_i(cm_valid), .sub_tag_i(cm_tag),
        .free_o(free_vec)
    );

    always_comb begin
        st_d          = st_q;
        st_d.valid    = fire ? op_valid : '0;
        st_d.elim     = g_elim;
        st_d.dst_zero = g_dzero;
        st_d.dst_tag  = g_dtag;
        st_d.prev_v   = g_pv;
        st_d.prev_tag = g_ptag;
        st_d.src_dep  = g_sdep;
        st_d.src_zero = g_szero;
        st_d.src_tag  = g_stag;
        if (fire) begin
            st_d.map_tag  = nxt_tag;
            st_d.map_zero = nxt_zero;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.map_zero <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign rn_valid      = st_q.valid;
    assign rn_elim       = st_q.elim;
    assign rn_dst_zero   = st_q.dst_zero;
    assign rn_dst_tag    = st_q.dst_tag;
    assign rn_prev_valid = st_q.prev_v;
    assign rn_prev_tag   = st_q.prev_tag;
    assign rn_src_dep    = st_q.src_dep;
    assign rn_src_zero   = st_q.src_zero;
    assign rn_src_tag    = st_q.src_tag;

    // R10: a refused group produces no renamed slot
    p_stall_silent_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |=> rn_valid == '0);
    // R11: an accepted group appears exactly one clock later
    p_one_cycle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |=> rn_valid == $past(op_valid));

    for (genvar g = 0; g < GROUP; g++) begin : g_chk
        // R2: the picker hands out only registers the counters call free
        p_alloc_free_r2: assert property (@(posedge clk) disable iff (!rst_n)
            fire && alloc_v[g] |-> free_vec[alloc_tag[g]]);
        // R6: eliminated slots never wait on a producer
        p_elim_no_dep_r6: assert property (@(posedge clk) disable iff (!rst_n)
            rn_valid[g] && rn_elim[g] |-> rn_src_dep[g] == 2'b00);
    end
endmodule

// File: tb/test_rename_core.sv
module test_rename_core;
    localparam int CLK_PERIOD = 10;
    localparam int G = 6;

    typedef struct packed {
        logic [1:0] cls;
        logic [3:0] dst;
        logic       s1en;
        logic [3:0] s1;
        logic       s2en;
        logic [3:0] s2;
        logic       e_elim;
        logic       e_zero;
        logic [7:0] e_tag;
        logic       e_dep;
        logic       e_s1z;
        logic [7:0] e_s1tag;
        logic       e_pv;
        logic [7:0] e_ptag;
    } vec_t;

    // cls: 0 normal, 1 move, 2 zero idiom
    localparam vec_t VEC [8] = '{
        '{2'd0, 4'd1, 1'b1, 4'd2, 1'b1, 4'd3, 1'b0, 1'b0, 8'd0, 1'b0, 1'b1, 8'd0, 1'b0, 8'd0},
        '{2'd0, 4'd2, 1'b1, 4'd1, 1'b0, 4'd0, 1'b0, 1'b0, 8'd1, 1'b1, 1'b0, 8'd0, 1'b0, 8'd0},
        '{2'd1, 4'd3, 1'b1, 4'd1, 1'b0, 4'd0, 1'b1, 1'b0, 8'd0, 1'b0, 1'b0, 8'd0, 1'b0, 8'd0},
        '{2'd0, 4'd4, 1'b1, 4'd3, 1'b0, 4'd0, 1'b0, 1'b0, 8'd2, 1'b1, 1'b0, 8'd0, 1'b0, 8'd0},
        '{2'd1, 4'd5, 1'b1, 4'd6, 1'b0, 4'd0, 1'b1, 1'b1, 8'd0, 1'b0, 1'b1, 8'd0, 1'b0, 8'd0},
        '{2'd2, 4'd1, 1'b1, 4'd1, 1'b1, 4'd1, 1'b1, 1'b1, 8'd0, 1'b0, 1'b0, 8'd0, 1'b1, 8'd0},
        '{2'd0, 4'd6, 1'b1, 4'd1, 1'b0, 4'd0, 1'b0, 1'b0, 8'd3, 1'b0, 1'b1, 8'd0, 1'b0, 8'd0},
        '{2'd0, 4'd3, 1'b1, 4'd4, 1'b0, 4'd0, 1'b0, 1'b0, 8'd4, 1'b1, 1'b0, 8'd2, 1'b1, 8'd0}
    };

    logic                    clk = 1'b0;
    logic                    rst_n;
    logic [G-1:0]            op_valid;
    logic [G-1:0][1:0]       op_cls;
    logic [G-1:0]            op_dst_en;
    logic [G-1:0][3:0]       op_dst;
    logic [G-1:0][1:0]       op_src_en;
    logic [G-1:0][1:0][3:0]  op_src;
    logic                    in_ready;
    logic [G-1:0]            cm_valid;
    logic [G-1:0][7:0]       cm_tag;
    logic [G-1:0]            rn_valid, rn_elim, rn_dst_zero, rn_prev_valid;
    logic [G-1:0][7:0]       rn_dst_tag, rn_prev_tag;
    logic [G-1:0][1:0]       rn_src_dep, rn_src_zero;
    logic [G-1:0][1:0][7:0]  rn_src_tag;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rename_core i_rename_core (
        .clk(clk), .rst_n(rst_n),
        .op_valid(op_valid), .op_cls(op_cls), .op_dst_en(op_dst_en), .op_dst(op_dst),
        .op_src_en(op_src_en), .op_src(op_src), .in_ready(in_ready),
        .cm_valid(cm_valid), .cm_tag(cm_tag),
        .rn_valid(rn_valid), .rn_elim(rn_elim), .rn_dst_zero(rn_dst_zero),
        .rn_dst_tag(rn_dst_tag), .rn_prev_valid(rn_prev_valid), .rn_prev_tag(rn_prev_tag),
        .rn_src_dep(rn_src_dep), .rn_src_zero(rn_src_zero), .rn_src_tag(rn_src_tag)
    );

    task automatic chk(input string req, input string what, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
        end
    endtask

    task automatic clear_ops();
        op_valid = '0; op_cls = '0; op_dst_en = '0; op_dst = '0;
        op_src_en = '0; op_src = '0; cm_valid = '0; cm_tag = '0;
    endtask

    task automatic set_op(input int s, input int cls, input int dst,
                          input int s1en, input int s1, input int s2en, input int s2);
        op_valid[s]     = 1'b1;
        op_cls[s]       = 2'(cls);
        op_dst_en[s]    = 1'b1;
        op_dst[s]       = 4'(dst);
        op_src_en[s]    = {1'(s2en), 1'(s1en)};
        op_src[s][0]    = 4'(s1);
        op_src[s][1]    = 4'(s2);
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic commit(input int tag);
        clear_ops();
        cm_valid[0] = 1'b1;
        cm_tag[0]   = 8'(tag);
        step();
        clear_ops();
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish");
            summary();
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        clear_ops();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk("R1", "rn_valid after reset", int'(rn_valid), 0);
        chk("R1", "in_ready after reset", int'(in_ready), 1);

        // single-op chain: R1 zero sources, R2..R6, R8
        for (int v = 0; v < 8; v++) begin
            clear_ops();
            set_op(0, VEC[v].cls, VEC[v].dst, VEC[v].s1en, VEC[v].s1, VEC[v].s2en, VEC[v].s2);
            step();
            chk("R11", $sformatf("vec%0d valid", v), int'(rn_valid[0]), 1);
            chk("R4/R6", $sformatf("vec%0d elim", v), int'(rn_elim[0]), int'(VEC[v].e_elim));
            chk("R5/R6", $sformatf("vec%0d dst_zero", v), int'(rn_dst_zero[0]), int'(VEC[v].e_zero));
            chk("R2/R4", $sformatf("vec%0d dst_tag", v), int'(rn_dst_tag[0]), int'(VEC[v].e_tag));
            chk("R3", $sformatf("vec%0d src dep", v), int'(rn_src_dep[0][0]), int'(VEC[v].e_dep));
            chk("R3", $sformatf("vec%0d src zero", v), int'(rn_src_zero[0][0]), int'(VEC[v].e_s1z));
            chk("R3", $sformatf("vec%0d src tag", v), int'(rn_src_tag[0][0]), int'(VEC[v].e_s1tag));
            chk("R8", $sformatf("vec%0d prev valid", v), int'(rn_prev_valid[0]), int'(VEC[v].e_pv));
            chk("R8", $sformatf("vec%0d prev tag", v), int'(rn_prev_tag[0]), int'(VEC[v].e_ptag));
        end
        clear_ops();
        step();
        chk("R11", "idle cycle rn_valid", int'(rn_valid), 0);

        // R9: tag 0 carries two references (write + move)
        commit(0);
        set_op(0, 0, 7, 0, 0, 0, 0);
        step();
        chk("R9", "tag 0 still held after one release", int'(rn_dst_tag[0]), 5);
        commit(0);
        set_op(0, 0, 8, 0, 0, 0, 0);
        step();
        chk("R9", "tag 0 reused after second release", int'(rn_dst_tag[0]), 0);

        // R7: chaining inside one group
        clear_ops();
        set_op(0, 0, 9, 1, 1, 0, 0);
        set_op(1, 1, 10, 1, 9, 0, 0);
        set_op(2, 0, 11, 1, 10, 1, 9);
        set_op(3, 2, 9, 0, 0, 0, 0);
        set_op(4, 0, 12, 1, 9, 0, 0);
        step();
        chk("R7", "slot0 tag", int'(rn_dst_tag[0]), 6);
        chk("R7", "slot1 move copies slot0 tag", int'(rn_dst_tag[1]), 6);
        chk("R7", "slot2 tag skips move", int'(rn_dst_tag[2]), 7);
        chk("R7", "slot2 src0 tag", int'(rn_src_tag[2][0]), 6);
        chk("R7", "slot2 src1 tag", int'(rn_src_tag[2][1]), 6);
        chk("R7", "slot2 deps", int'(rn_src_dep[2]), 3);
        chk("R7", "slot3 prev tag", int'(rn_prev_tag[3]), 6);
        chk("R7", "slot4 sees zeroed source", int'(rn_src_zero[4][0]), 1);
        chk("R7", "slot4 tag", int'(rn_dst_tag[4]), 8);

        // drain pool: tags 9..176
        for (int g = 0; g < 28; g++) begin
            clear_ops();
            for (int s = 0; s < G; s++) set_op(s, 0, 13, 0, 0, 0, 0);
            step();
            if (g == 0)  chk("R2", "first fill tag", int'(rn_dst_tag[0]), 9);
            if (g == 27) chk("R2", "last fill tag", int'(rn_dst_tag[5]), 176);
        end

        // R10: six writers, three free
        clear_ops();
        for (int s = 0; s < G; s++) set_op(s, 0, 13, 0, 0, 0, 0);
        #1;
        chk("R10", "ready with too few free", int'(in_ready), 0);
        step();
        chk("R10", "stalled group not renamed", int'(rn_valid), 0);

        clear_ops();
        set_op(0, 0, 15, 1, 13, 0, 0);
        #1;
        chk("R10", "ready with enough free", int'(in_ready), 1);
        step();
        chk("R10", "map unchanged by stall", int'(rn_src_tag[0][0]), 176);
        chk("R10", "pool unchanged by stall", int'(rn_dst_tag[0]), 177);

        clear_ops();
        set_op(0, 0, 13, 0, 0, 0, 0);
        set_op(1, 0, 13, 0, 0, 0, 0);
        set_op(2, 1, 14, 1, 13, 0, 0);
        step();
        chk("R2", "slot1 tag", int'(rn_dst_tag[1]), 179);
        chk("R4", "move of last tag", int'(rn_dst_tag[2]), 179);
        chk("R8", "slot1 prev is slot0", int'(rn_prev_tag[1]), 178);

        clear_ops();
        set_op(0, 0, 2, 0, 0, 0, 0);
        #1;
        chk("R10", "ready with empty pool", int'(in_ready), 0);
        clear_ops();
        set_op(0, 2, 15, 1, 3, 0, 0);
        #1;
        chk("R10", "zero idiom passes empty pool", int'(in_ready), 1);
        step();
        chk("R6", "zero idiom no source zero", int'(rn_src_zero[0]), 0);
        chk("R8", "zero idiom prev tag", int'(rn_prev_tag[0]), 177);

        commit(177);
        set_op(0, 0, 1, 0, 0, 0, 0);
        step();
        chk("R9", "single-ref tag reused", int'(rn_dst_tag[0]), 177);
        clear_ops();
        step();

        done = 1'b1;
        summary();
        $finish;
    end
endmodule